// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down-counters. All three are programmed and read over one byte-wide register bus with a two-bit address. Address 3 takes command bytes. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2. A command byte either programs a channel's operating mode, freezes a channel's count for reading, or snapshots status for one or more channels. Counts are loaded as two byte writes, and reads return bytes in the same low-then-high order.

The whole block runs on one system clock. Each channel has a count-enable input (`ch_tick`) that stands in for the channel's own clock, plus a gate input and an output. Three behaviours are provided:

- terminal-count flag (mode 0)
- periodic one-tick low pulse (mode 2)
- square wave (mode 3)

A loaded value of zero counts as 65536. The register bus has no back-pressure: every write or read strobe is taken in the cycle it is presented. Read data is combinational during the read strobe, and all state changes occur at the following clock edge.

Top module: `interval_timer_bank`

## Requirements
- R1: Address 3 is the command port and addresses 0..2 are the data ports of channels 0..2. In a command byte, bits 7:6 select the channel, bits 5:4 the access type, bits 3:1 the mode, and bit 0 is a stored, otherwise unused decimal flag. Only access 11 with mode 0, 2 or 3 programs a channel. Program bytes with any other mode, and access types 01 or 10, leave every channel unchanged.
- R2: Reset drives all outputs and error flags low. A program byte stops its channel, resets that channel's byte pointers and latch, and sets its output low for mode 0 or high for modes 2 and 3.
- R3: A count is written low byte first, then high byte. The count takes effect on the high-byte write, and a value of 0 means 65536.
- R4: In mode 0 the output is low after a load and rises on the N-th qualifying tick. It then stays high, and the count holds at 0 until the next load or program byte.
- R5: In mode 2 the output falls on the (N-1)-th qualifying tick, returns high on the N-th tick, and the count reloads, so the period is N ticks.
- R6: In mode 3 the output is high for ceil(N/2) qualifying ticks and low for floor(N/2) ticks, repeating. The live count shows the ticks left in the current half.
- R7: A tick counts only while that channel's gate is high. A low gate freezes both the count and the output.
- R8: Loading 1 in mode 2 or 3 raises that channel's `ch_bad` and leaves the channel stopped with its output unchanged. A legal load or a program byte clears `ch_bad`.
- R9: A command byte with access 00 freezes the selected channel's count. The next two reads of its port return the frozen low byte, then the high byte. Further latch commands are ignored until both bytes are read.
- R10: A command byte with bits 7:5 = 111 snapshots status for each channel whose bit (1 + channel) is set. The next read of that channel's port returns {output, null flag, access[1:0], mode[2:0], decimal flag}, from bit 7 down to bit 0.
- R11: The null flag is set by a program byte and by a low-byte write. It is cleared by a legal high-byte load.
- R12: Without a latch or status pending, reads of a data port return the live count, alternating low and high bytes. `bus_rdata` is 0 when no data port is being read, including reads of address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_rd | input | 1 | Read strobe, one cycle per byte |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while `bus_rd` is high |
| ch_tick | input | 3 | Per-channel count enable |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel timer output |
| ch_bad | output | 3 | Per-channel illegal-count flag |

## Verification
Read data is due in the same cycle as the read strobe. The bench therefore compares `bus_rdata` one time step after driving the strobe, before the edge that advances the byte pointer. Outputs, error flags and counts change at the edge that samples a write or a tick. The bench updates its behavioural model at that edge and compares every output one time step later, on every clock. Latch and status snapshots take the count and output from before that edge's tick, and the model applies them in that order.

// File: rtl/itb_pkg.sv
package itb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(3);

  localparam logic [2:0] MODE_TC   = 3'd0;
  localparam logic [2:0] MODE_RATE = 3'd2;
  localparam logic [2:0] MODE_SQ   = 3'd3;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_WORD  = 2'b11;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] mode;
    logic       dec;
  } cmd_t;
endpackage

// File: rtl/itb_decode.sv
module itb_decode
  import itb_pkg::*;
(
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] prog,
  output logic [NUM_CH-1:0] latch,
  output logic [NUM_CH-1:0] stat,
  output logic [NUM_CH-1:0] dwr,
  output logic [NUM_CH-1:0] drd
);
  cmd_t cmd;
  logic is_cmd, is_rb, mode_ok;

  assign cmd     = cmd_t'(wdata);
  assign is_cmd  = wr && (addr == CMD_ADDR);
  assign is_rb   = (cmd.sel == 2'b11) && cmd.acc[1];
  assign mode_ok = (cmd.mode == MODE_TC) || (cmd.mode == MODE_RATE) || (cmd.mode == MODE_SQ);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit      = is_cmd && !is_rb && (cmd.sel == 2'(c));
    assign prog[c]  = hit && (cmd.acc == ACC_WORD) && mode_ok;
    assign latch[c] = hit && (cmd.acc == ACC_LATCH);
    assign stat[c]  = is_cmd && is_rb && wdata[1+c];
    assign dwr[c]   = wr && (addr == ADDR_W'(c));
    assign drd[c]   = rd && !wr && (addr == ADDR_W'(c));
  end
endmodule

// File: rtl/itb_channel.sv
module itb_channel
  import itb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              latch,
  input  logic              stat,
  input  logic              dwr,
  input  logic              drd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic              gate,
  output logic [BYTE_W-1:0] rbyte,
  output logic              out,
  output logic              bad
);
  localparam int VW = CNT_W + 1;

  logic [2:0]        mode_q;
  logic [1:0]        acc_q;
  logic              dec_q, wptr_q, rptr_q, out_q, null_q, run_q, bad_q, lat_q, st_q;
  logic [BYTE_W-1:0] lo_q, stb_q;
  logic [VW-1:0]     nval_q, ce_q, nce, ld_val;
  logic [CNT_W-1:0]  lval_q, raw;
  logic              nout, ld_bad;

  assign raw    = {wdata, lo_q};
  assign ld_val = (raw == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, raw};
  assign ld_bad = ((mode_q == MODE_RATE) || (mode_q == MODE_SQ)) && (raw == CNT_W'(1));

  always_comb begin
    nce  = ce_q;
    nout = out_q;
    case (mode_q)
      MODE_TC: if (ce_q != '0) begin
        nce = ce_q - VW'(1);
        if (ce_q == VW'(1)) nout = 1'b1;
      end
      MODE_RATE: if (ce_q == VW'(1)) begin
        nce  = nval_q;
        nout = 1'b1;
      end else begin
        nce = ce_q - VW'(1);
        if (ce_q == VW'(2)) nout = 1'b0;
      end
      MODE_SQ: if (ce_q == VW'(1)) begin
        nout = ~out_q;
        nce  = out_q ? (nval_q >> 1) : ((nval_q + VW'(1)) >> 1);
      end else begin
        nce = ce_q - VW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_TC; acc_q <= '0; dec_q <= 1'b0;
      wptr_q <= 1'b0; lo_q <= '0; nval_q <= '0; ce_q <= '0;
      out_q <= 1'b0; null_q <= 1'b1; run_q <= 1'b0; bad_q <= 1'b0;
    end else if (prog) begin
      mode_q <= wdata[3:1]; acc_q <= wdata[5:4]; dec_q <= wdata[0];
      wptr_q <= 1'b0; out_q <= (wdata[3:1] != MODE_TC);
      null_q <= 1'b1; run_q <= 1'b0; bad_q <= 1'b0;
    end else if (dwr) begin
      if (!wptr_q) begin
        lo_q <= wdata; wptr_q <= 1'b1; null_q <= 1'b1;
      end else begin
        wptr_q <= 1'b0;
        if (ld_bad) begin
          bad_q <= 1'b1; run_q <= 1'b0;
        end else begin
          bad_q <= 1'b0; run_q <= 1'b1; null_q <= 1'b0; nval_q <= ld_val;
          ce_q  <= (mode_q == MODE_SQ) ? ((ld_val + VW'(1)) >> 1) : ld_val;
          out_q <= (mode_q != MODE_TC);
        end
      end
    end else if (tick && gate && run_q) begin
      ce_q  <= nce;
      out_q <= nout;
    end
  end

  // Read side: latch, status snapshot and byte pointer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rptr_q <= 1'b0; lat_q <= 1'b0; lval_q <= '0; st_q <= 1'b0; stb_q <= '0;
    end else begin
      if (drd) begin
        if (st_q) st_q <= 1'b0;
        else begin
          rptr_q <= ~rptr_q;
          if (lat_q && rptr_q) lat_q <= 1'b0;
        end
      end
      if (latch && !lat_q) begin
        lat_q <= 1'b1; lval_q <= ce_q[CNT_W-1:0]; rptr_q <= 1'b0;
      end
      if (stat) begin
        st_q  <= 1'b1;
        stb_q <= {out_q, null_q, acc_q, mode_q, dec_q};
      end
      if (prog) begin
        rptr_q <= 1'b0; lat_q <= 1'b0; st_q <= 1'b0;
      end
    end
  end

  always_comb begin
    if (st_q)       rbyte = stb_q;
    else if (lat_q) rbyte = rptr_q ? lval_q[CNT_W-1:BYTE_W] : lval_q[BYTE_W-1:0];
    else            rbyte = rptr_q ? ce_q[CNT_W-1:BYTE_W] : ce_q[BYTE_W-1:0];
  end

  assign out = out_q;
  assign bad = bad_q;

  AST_TC_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_TC && out_q && !prog && !dwr) |=> out_q); // R4
  AST_RATE_ONE_TICK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RATE && run_q && !out_q && tick && gate && !prog && !dwr) |=> out_q); // R5
  AST_SQ_NEVER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && mode_q == MODE_SQ) |-> (ce_q != '0)); // R6
  AST_GATE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && gate) && !prog && !dwr) |=> ($stable(ce_q) && $stable(out_q))); // R7
  AST_BAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> !run_q); // R8
endmodule

// File: rtl/interval_timer_bank.sv
module interval_timer_bank
  import itb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] ch_tick,
  input  logic [NUM_CH-1:0] ch_gate,
  output logic [NUM_CH-1:0] ch_out,
  output logic [NUM_CH-1:0] ch_bad
);
  logic [NUM_CH-1:0] prog, latch, stat, dwr, drd;
  logic [BYTE_W-1:0] rbyte [NUM_CH];

  itb_decode u_dec (
    .wr(bus_wr), .rd(bus_rd), .addr(bus_addr), .wdata(bus_wdata),
    .prog(prog), .latch(latch), .stat(stat), .dwr(dwr), .drd(drd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    itb_channel u_ch (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[c]), .latch(latch[c]), .stat(stat[c]), .dwr(dwr[c]), .drd(drd[c]),
      .wdata(bus_wdata), .tick(ch_tick[c]), .gate(ch_gate[c]),
      .rbyte(rbyte[c]), .out(ch_out[c]), .bad(ch_bad[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (drd[c]) bus_rdata = rbyte[c];
  end

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0)); // R12
  AST_ONE_PORT_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drd)); // R1
endmodule

// File: tb/interval_timer_bank_tb.sv
`timescale 1ns/1ps
module interval_timer_bank_tb;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [2:0] ch_tick = 0, ch_gate = 3'b111;
  logic [2:0] ch_out, ch_bad;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  interval_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tick(ch_tick), .ch_gate(ch_gate),
    .ch_out(ch_out), .ch_bad(ch_bad)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int m_mode[3], m_acc[3], m_dec[3], m_wp[3], m_lo[3], m_nv[3], m_ce[3], m_out[3];
  int m_null[3], m_run[3], m_bad[3], m_lat[3], m_lv[3], m_rp[3], m_st[3], m_sb[3];

  task automatic model_reset();
    for (int c = 0; c < 3; c++) begin
      m_mode[c] = 0; m_acc[c] = 0; m_dec[c] = 0; m_wp[c] = 0; m_lo[c] = 0; m_nv[c] = 0;
      m_ce[c] = 0; m_out[c] = 0; m_null[c] = 1; m_run[c] = 0; m_bad[c] = 0;
      m_lat[c] = 0; m_lv[c] = 0; m_rp[c] = 0; m_st[c] = 0; m_sb[c] = 0;
    end
  endtask

  function automatic int model_read(int a);
    int v;
    if (a > 2) return 0;
    if (m_st[a] != 0) return m_sb[a];
    v = (m_lat[a] != 0) ? m_lv[a] : (m_ce[a] % 65536);
    return (m_rp[a] != 0) ? (v / 256) % 256 : v % 256;
  endfunction

  task automatic model_clock(bit wr, bit rd, int a, int d, logic [2:0] tk, logic [2:0] gt);
    for (int c = 0; c < 3; c++) begin
      bit busy = 0;
      if (wr && a == 3) begin
        int sel = d / 64, acc = (d / 16) % 4, md = (d / 2) % 8;
        if (sel == 3 && acc >= 2) begin
          if (d[1+c]) begin
            m_st[c] = 1;
            m_sb[c] = m_out[c]*128 + m_null[c]*64 + m_acc[c]*16 + m_mode[c]*2 + m_dec[c];
          end
        end else if (sel == c && acc == 0) begin
          if (m_lat[c] == 0) begin m_lat[c] = 1; m_lv[c] = m_ce[c] % 65536; m_rp[c] = 0; end
        end else if (sel == c && acc == 3 && (md == 0 || md == 2 || md == 3)) begin
          busy = 1;
          m_mode[c] = md; m_acc[c] = 3; m_dec[c] = d % 2; m_wp[c] = 0; m_rp[c] = 0;
          m_lat[c] = 0; m_st[c] = 0; m_out[c] = (md == 0) ? 0 : 1;
          m_null[c] = 1; m_run[c] = 0; m_bad[c] = 0;
        end
      end
      if (wr && a == c) begin
        busy = 1;
        if (m_wp[c] == 0) begin m_lo[c] = d; m_wp[c] = 1; m_null[c] = 1; end
        else begin
          int val = m_lo[c] + 256 * d;
          m_wp[c] = 0;
          if ((m_mode[c] == 2 || m_mode[c] == 3) && val == 1) begin
            m_bad[c] = 1; m_run[c] = 0;
          end else begin
            m_nv[c] = (val == 0) ? 65536 : val;
            m_bad[c] = 0; m_run[c] = 1; m_null[c] = 0;
            m_ce[c] = (m_mode[c] == 3) ? (m_nv[c] + 1) / 2 : m_nv[c];
            m_out[c] = (m_mode[c] == 0) ? 0 : 1;
          end
        end
      end
      if (!busy && tk[c] && gt[c] && m_run[c] != 0) begin
        case (m_mode[c])
          0: if (m_ce[c] > 0) begin m_ce[c]--; if (m_ce[c] == 0) m_out[c] = 1; end
          2: if (m_ce[c] == 1) begin m_ce[c] = m_nv[c]; m_out[c] = 1; end
             else begin m_ce[c]--; if (m_ce[c] == 1) m_out[c] = 0; end
          default: if (m_ce[c] == 1) begin
                     if (m_out[c] != 0) begin m_out[c] = 0; m_ce[c] = m_nv[c] / 2; end
                     else begin m_out[c] = 1; m_ce[c] = (m_nv[c] + 1) / 2; end
                   end else m_ce[c]--;
        endcase
      end
      if (rd && !wr && a == c) begin
        if (m_st[c] != 0) m_st[c] = 0;
        else begin
          if (m_lat[c] != 0 && m_rp[c] == 1) m_lat[c] = 0;
          m_rp[c] = 1 - m_rp[c];
        end
      end
    end
  endtask

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(int c);
    case (m_mode[c])
      0: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // One clock: drive, check read data before the edge, update model after it, compare.
  task automatic cyc(bit wr, bit rd, int a, int d, logic [2:0] tk, string tag);
    bus_wr = wr; bus_rd = rd; bus_addr = 2'(a); bus_wdata = 8'(d); ch_tick = tk;
    #1;
    check(tag, int'(bus_rdata), (rd && !wr) ? model_read(a) : 0);
    @(posedge clk); #1;
    model_clock(wr, rd, a, d, tk, ch_gate);
    for (int c = 0; c < 3; c++) begin
      check(mode_tag(c), int'(ch_out[c]), m_out[c]);
      check("R8", int'(ch_bad[c]), m_bad[c]);
    end
  endtask

  task automatic wr_b(int a, int d, string tag); cyc(1, 0, a, d, 3'b000, tag); endtask
  task automatic rd_b(int a, string tag);        cyc(0, 1, a, 0, 3'b000, tag); endtask
  task automatic ticks(int n, logic [2:0] tk, string tag);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tk, tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    for (int c = 0; c < 3; c++) begin   // R2 reset state
      check("R2", int'(ch_out[c]), 0);
      check("R2", int'(ch_bad[c]), 0);
    end
    rst_n = 1'b1;
    rd_b(3, "R12");                      // command port reads 0
    rd_b(0, "R12"); rd_b(0, "R12");      // live count bytes
    // R1 R2: program ch0 mode0, ch1 mode2, ch2 mode3
    wr_b(3, 8'h30, "R1"); wr_b(3, 8'h74, "R1"); wr_b(3, 8'hB6, "R2");
    // R3: counts 5, 4, 5 loaded low then high
    wr_b(0, 5, "R3"); wr_b(0, 0, "R3");
    wr_b(1, 4, "R3"); wr_b(1, 0, "R3");
    wr_b(2, 5, "R3"); wr_b(2, 0, "R3");
    ticks(14, 3'b111, "R4");             // R4 R5 R6
    ticks(12, 3'b010, "R5");             // sparse ticks
    ch_gate = 3'b101;                    // R7 gate low freezes ch1
    ticks(6, 3'b111, "R7");
    ch_gate = 3'b111;
    ticks(5, 3'b111, "R7");
    // R9 latch ch2, tick on, read frozen bytes; second latch ignored
    wr_b(3, 8'h80, "R9");
    ticks(3, 3'b111, "R9");
    rd_b(2, "R9");
    wr_b(3, 8'h80, "R9");
    ticks(2, 3'b111, "R9");
    rd_b(2, "R9");
    rd_b(2, "R12"); rd_b(2, "R12");
    // R10 status snapshot of ch1 only, then live reads resume
    wr_b(3, 8'hE4, "R10");
    rd_b(0, "R10"); rd_b(1, "R10"); rd_b(1, "R12"); rd_b(1, "R12");
    // R8 illegal count in mode 2
    wr_b(3, 8'h74, "R8"); wr_b(1, 1, "R8"); wr_b(1, 0, "R8");
    ticks(4, 3'b111, "R8");
    wr_b(3, 8'hE4, "R11"); rd_b(1, "R11");
    wr_b(1, 3, "R11");                   // R11 low byte sets null
    wr_b(3, 8'hE4, "R11"); rd_b(1, "R11");
    wr_b(1, 0, "R8");                    // legal load clears bad
    wr_b(3, 8'hE4, "R11"); rd_b(1, "R11");
    ticks(7, 3'b111, "R5");
    // R3 zero count means 65536 in mode 0
    wr_b(3, 8'h30, "R3"); wr_b(0, 0, "R3"); wr_b(0, 0, "R3");
    ticks(10, 3'b001, "R3");
    wr_b(3, 8'h00, "R3"); rd_b(0, "R3"); rd_b(0, "R3");
    // R1 ignored program bytes: mode 4 and access 01 on ch0
    wr_b(3, 8'h38, "R1"); wr_b(3, 8'h10, "R1");
    ticks(2, 3'b001, "R1");
    wr_b(3, 8'hE2, "R1"); rd_b(0, "R1");
    // R6 even count on ch2, illegal count 1 in mode 3
    wr_b(3, 8'hB6, "R6"); wr_b(2, 6, "R6"); wr_b(2, 0, "R6");
    ticks(14, 3'b100, "R6");
    wr_b(3, 8'hB6, "R8"); wr_b(2, 1, "R8"); wr_b(2, 0, "R8");
    ticks(3, 3'b100, "R8");
    wr_b(3, 8'hEE, "R10"); rd_b(0, "R10"); rd_b(1, "R10"); rd_b(2, "R10");
    ticks(2, 3'b000, "R12");
    finish_up();
  end
endmodule